// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block decides which pad of a 16-pin bank each on-chip peripheral signal drives. The bank is two 8-pin ports; global pin index `8*port + pin` runs from 0 (port 0, pin 0) to 15 (port 1, pin 7). Seventeen peripheral signals are ranked by fixed priority. The UART pair and the comparator output pair have fixed pins. Every other enabled signal, in priority order, claims the lowest-numbered pin that is neither already claimed nor masked off by software.

Software drives a per-signal enable vector and a 4-wire SPI mode flag directly. It loads one 8-bit skip mask per port through a small register write port. Skip masks reserve pins for analog use, for dedicated functions or for plain GPIO. The block reports two registered views of the result: for each pin, the owning signal; for each signal, the pin it was given. Pad multiplexing itself lies outside this block.

Top module: `pin_xbar`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), both skip masks are 0x00 and every `pin_vld` and `sig_vld` bit is 0.
- R2: Signal codes, highest priority first, are 0 UART transmit, 1 UART receive, 2 comparator async output, 3 comparator sync output, 4 SPI clock, 5 SPI MISO, 6 SPI MOSI, 7 SPI slave select, 8 I2C data, 9 I2C clock, 10 system clock out, 11..13 capture/compare channels 0..2, 14 counter external clock, 15 timer 0, 16 timer 1. `pin_owner` holds the 5-bit code of the owning signal in bits `[5*p +: 5]` for pin p. `sig_pin` holds the 4-bit global pin index of signal s in bits `[4*s +: 4]`.
- R3: Each enabled non-fixed signal, in ascending code order, is given the lowest global pin index that is free and not skipped.
- R4: Bit n of the skip mask written at address 0 (port 0) or address 1 (port 1) removes global pin `8*addr + n` from the walk. Writes take effect when `cfg_we` is high at a clock edge.
- R5: When enabled, signals 0 and 1 always go to global pins 4 and 5, whatever the skip masks say.
- R6: When enabled, signals 2 and 3 always go to global pins 12 and 13, whatever the skip masks say.
- R7: A fixed pin is withheld from the walk only while its fixed signal is enabled. Otherwise it is an ordinary candidate.
- R8: Signal 7 is allocated only while `spi4_mode` is 1. Otherwise its `sig_vld` is 0 and it consumes no pin.
- R9: An enabled signal that finds no eligible pin has `sig_vld` 0. No pin names it as owner, and every pin not given to a signal has `pin_vld` 0.
- R10: The outputs reflect the enables, the mode and the skip masks (including a write made in the same cycle) as sampled at the most recent clock edge, one clock after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_en | input | 17 | Per-signal enable, bit s = signal code s |
| spi4_mode | input | 1 | 1 = SPI slave select takes part in allocation |
| cfg_we | input | 1 | Skip-mask write strobe |
| cfg_addr | input | 1 | Skip-mask select: 0 = port 0, 1 = port 1 |
| cfg_wdata | input | 8 | Skip-mask write data, bit n = pin n |
| pin_vld | output | 16 | Pin p is given to a signal |
| pin_owner | output | 80 | Owner code per pin, 5 bits each |
| sig_vld | output | 17 | Signal s holds a pin |
| sig_pin | output | 68 | Global pin index per signal, 4 bits each |

## Verification
A stale or corrupted skip mask shows up in the very next cycle's outputs: a masked pin appears as owned by a walking signal, or every later signal in priority order is shifted by one pin. Bad reservation of the fixed pins shows as a pin held by two signals at once, or as a walking signal landing on pin 4, 5, 12 or 13 while its fixed owner is enabled. Because the whole decode is recomputed every clock, an error needs no history to appear. It is visible one edge after the configuration that provokes it, and the two output views then disagree, or the masked pin or shift is visible directly.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int N_SIG  = 17;
  localparam int SIG_W  = $clog2(N_SIG);
  localparam int N_PORT = 2;
  localparam int PORT_W = 8;
  localparam int N_PIN  = N_PORT * PORT_W;
  localparam int PIN_W  = $clog2(N_PIN);

  localparam int SIG_UTX  = 0;
  localparam int SIG_URX  = 1;
  localparam int SIG_CMPA = 2;
  localparam int SIG_CMPS = 3;
  localparam int SIG_SSEL = 7;

  function automatic logic is_fixed(input int s);
    return (s == SIG_UTX) || (s == SIG_URX) || (s == SIG_CMPA) || (s == SIG_CMPS);
  endfunction

  function automatic logic [PIN_W-1:0] fixed_pin(input int s);
    case (s)
      SIG_UTX:  return PIN_W'(4);
      SIG_URX:  return PIN_W'(5);
      SIG_CMPA: return PIN_W'(PORT_W + 4);
      SIG_CMPS: return PIN_W'(PORT_W + 5);
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/xbar_skip_regs.sv
module xbar_skip_regs #(
  parameter int N_PORT = 2,
  parameter int PORT_W = 8,
  localparam int N_PIN = N_PORT * PORT_W,
  localparam int ADDR_W = (N_PORT > 1) ? $clog2(N_PORT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] wdata,
  output logic [N_PIN-1:0]  skip_q,
  output logic [N_PIN-1:0]  skip_next
);
  for (genvar g = 0; g < N_PORT; g++) begin : g_port
    logic hit;
    assign hit = we && (addr == ADDR_W'(g));
    assign skip_next[g*PORT_W +: PORT_W] = hit ? wdata : skip_q[g*PORT_W +: PORT_W];

    always_ff @(posedge clk) begin
      if (rst) skip_q[g*PORT_W +: PORT_W] <= '0;
      else     skip_q[g*PORT_W +: PORT_W] <= skip_next[g*PORT_W +: PORT_W];
    end
  end

  // R4: a write lands in exactly the addressed port's mask
  assert_skip_write_R4: assert property (@(posedge clk) disable iff (rst)
    we |=> (skip_q[PORT_W*$past(addr) +: PORT_W] == $past(wdata)));
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_pkg::*;
(
  input  logic [N_SIG-1:0]       sig_en,
  input  logic                   spi4_mode,
  input  logic [N_PIN-1:0]       skip,
  output logic [N_PIN-1:0]       pin_vld_n,
  output logic [N_PIN*SIG_W-1:0] pin_owner_n,
  output logic [N_SIG-1:0]       sig_vld_n,
  output logic [N_SIG*PIN_W-1:0] sig_pin_n
);
  logic [N_SIG-1:0] elig;
  logic [N_PIN-1:0] taken;
  logic             found;

  always_comb begin
    elig = sig_en;
    if (!spi4_mode) elig[SIG_SSEL] = 1'b0;
  end

  always_comb begin
    taken       = '0;
    found       = 1'b0;
    pin_vld_n   = '0;
    pin_owner_n = '0;
    sig_vld_n   = '0;
    sig_pin_n   = '0;
    // fixed-location signals first; they ignore the skip masks
    for (int s = 0; s < N_SIG; s++) begin
      if (elig[s] && is_fixed(s)) begin
        taken[fixed_pin(s)]                     = 1'b1;
        pin_vld_n[fixed_pin(s)]                 = 1'b1;
        pin_owner_n[fixed_pin(s)*SIG_W +: SIG_W] = SIG_W'(s);
        sig_vld_n[s]                            = 1'b1;
        sig_pin_n[s*PIN_W +: PIN_W]             = fixed_pin(s);
      end
    end
    taken = taken | skip;
    // priority walk, lowest free pin wins
    for (int s = 0; s < N_SIG; s++) begin
      found = 1'b0;
      if (elig[s] && !is_fixed(s)) begin
        for (int p = 0; p < N_PIN; p++) begin
          if (!found && !taken[p]) begin
            found                       = 1'b1;
            taken[p]                    = 1'b1;
            pin_vld_n[p]                = 1'b1;
            pin_owner_n[p*SIG_W +: SIG_W] = SIG_W'(s);
            sig_vld_n[s]                = 1'b1;
            sig_pin_n[s*PIN_W +: PIN_W] = PIN_W'(p);
          end
        end
      end
    end
  end
endmodule

// File: rtl/xbar_out_reg.sv
module xbar_out_reg
  import xbar_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_PIN-1:0]       pin_vld_n,
  input  logic [N_PIN*SIG_W-1:0] pin_owner_n,
  input  logic [N_SIG-1:0]       sig_vld_n,
  input  logic [N_SIG*PIN_W-1:0] sig_pin_n,
  output logic [N_PIN-1:0]       pin_vld_q,
  output logic [N_PIN*SIG_W-1:0] pin_owner_q,
  output logic [N_SIG-1:0]       sig_vld_q,
  output logic [N_SIG*PIN_W-1:0] sig_pin_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_vld_q   <= '0;
      pin_owner_q <= '0;
      sig_vld_q   <= '0;
      sig_pin_q   <= '0;
    end else begin
      pin_vld_q   <= pin_vld_n;
      pin_owner_q <= pin_owner_n;
      sig_vld_q   <= sig_vld_n;
      sig_pin_q   <= sig_pin_n;
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import xbar_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SIG-1:0]       sig_en,
  input  logic                   spi4_mode,
  input  logic                   cfg_we,
  input  logic                   cfg_addr,
  input  logic [PORT_W-1:0]      cfg_wdata,
  output logic [N_PIN-1:0]       pin_vld,
  output logic [N_PIN*SIG_W-1:0] pin_owner,
  output logic [N_SIG-1:0]       sig_vld,
  output logic [N_SIG*PIN_W-1:0] sig_pin
);
  logic [N_PIN-1:0]       skip_q, skip_next;
  logic [N_PIN-1:0]       pin_vld_n;
  logic [N_PIN*SIG_W-1:0] pin_owner_n;
  logic [N_SIG-1:0]       sig_vld_n;
  logic [N_SIG*PIN_W-1:0] sig_pin_n;

  xbar_skip_regs #(.N_PORT(N_PORT), .PORT_W(PORT_W)) u_skip (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .skip_q(skip_q), .skip_next(skip_next)
  );

  xbar_alloc u_alloc (
    .sig_en(sig_en), .spi4_mode(spi4_mode), .skip(skip_next),
    .pin_vld_n(pin_vld_n), .pin_owner_n(pin_owner_n),
    .sig_vld_n(sig_vld_n), .sig_pin_n(sig_pin_n)
  );

  xbar_out_reg u_out (
    .clk(clk), .rst(rst),
    .pin_vld_n(pin_vld_n), .pin_owner_n(pin_owner_n),
    .sig_vld_n(sig_vld_n), .sig_pin_n(sig_pin_n),
    .pin_vld_q(pin_vld), .pin_owner_q(pin_owner),
    .sig_vld_q(sig_vld), .sig_pin_q(sig_pin)
  );

  // R8: slave select never allocated in 3-wire mode
  assert_ssel_mode_R8: assert property (@(posedge clk) disable iff (rst)
    !spi4_mode |=> !sig_vld[SIG_SSEL]);

  // R5: UART transmit sits on pin 4 when enabled
  assert_utx_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    sig_en[SIG_UTX] |=> (sig_vld[SIG_UTX] && sig_pin[SIG_UTX*PIN_W +: PIN_W] == PIN_W'(4)));

  // R6: comparator async output sits on pin 12 when enabled
  assert_cmp_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    sig_en[SIG_CMPA] |=> (sig_vld[SIG_CMPA] && sig_pin[SIG_CMPA*PIN_W +: PIN_W] == PIN_W'(12)));

  for (genvar s = 0; s < N_SIG; s++) begin : g_sig_chk
    // R9: both output views agree for every placed signal
    assert_views_agree_R9: assert property (@(posedge clk) disable iff (rst)
      sig_vld[s] |-> (pin_vld[sig_pin[s*PIN_W +: PIN_W]] &&
                      pin_owner[sig_pin[s*PIN_W +: PIN_W]*SIG_W +: SIG_W] == SIG_W'(s)));
  end

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin_chk
    // R4: a masked pin only ever carries a fixed-location signal
    assert_skip_honoured_R4: assert property (@(posedge clk) disable iff (rst)
      (pin_vld[p] && skip_q[p]) |-> is_fixed(int'(pin_owner[p*SIG_W +: SIG_W])));
    // R2: owner code is always a real signal
    assert_owner_range_R2: assert property (@(posedge clk) disable iff (rst)
      pin_vld[p] |-> (pin_owner[p*SIG_W +: SIG_W] < SIG_W'(N_SIG)));
  end
endmodule

// File: tb/pin_xbar_tb.sv
module pin_xbar_tb;
  localparam int NS = 17;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [NS-1:0] sig_en;
  logic          spi4_mode;
  logic          cfg_we;
  logic          cfg_addr;
  logic [7:0]    cfg_wdata;
  logic [NP-1:0] pin_vld;
  logic [NP*5-1:0] pin_owner;
  logic [NS-1:0] sig_vld;
  logic [NS*4-1:0] sig_pin;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] mask_now;

  always #2 clk = ~clk;

  pin_xbar u_dut (
    .clk(clk), .rst(rst), .sig_en(sig_en), .spi4_mode(spi4_mode),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pin_vld(pin_vld), .pin_owner(pin_owner), .sig_vld(sig_vld), .sig_pin(sig_pin)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected pin for signal s (-1 = none), written from the requirements
  function automatic void model(input logic [NS-1:0] en, input logic spi4,
                                input logic [15:0] mask, output int where [NS]);
    logic [15:0] used;
    used = mask;
    for (int s = 0; s < NS; s++) where[s] = -1;
    if (en[0]) begin where[0] = 4;  used[4]  = 1'b1; end
    if (en[1]) begin where[1] = 5;  used[5]  = 1'b1; end
    if (en[2]) begin where[2] = 12; used[12] = 1'b1; end
    if (en[3]) begin where[3] = 13; used[13] = 1'b1; end
    for (int s = 4; s < NS; s++) begin
      if (en[s] && (s != 7 || spi4)) begin
        for (int p = 0; p < NP; p++) begin
          if (where[s] < 0 && !used[p]) begin where[s] = p; used[p] = 1'b1; end
        end
      end
    end
  endfunction

  task automatic check_all(input string req);
    int where [NS];
    int own_exp [NP];
    model(sig_en, spi4_mode, mask_now, where);
    for (int p = 0; p < NP; p++) own_exp[p] = -1;
    for (int s = 0; s < NS; s++) begin
      chk(req, $sformatf("sig %0d valid", s), int'(sig_vld[s]), int'(where[s] >= 0));
      if (where[s] >= 0) begin
        chk(req, $sformatf("sig %0d pin", s), int'(sig_pin[s*4 +: 4]), where[s]);
        own_exp[where[s]] = s;
      end
    end
    for (int p = 0; p < NP; p++) begin
      chk(req, $sformatf("pin %0d valid", p), int'(pin_vld[p]), int'(own_exp[p] >= 0));
      if (own_exp[p] >= 0)
        chk(req, $sformatf("pin %0d owner", p), int'(pin_owner[p*5 +: 5]), own_exp[p]);
    end
  endtask

  task automatic apply(input logic [NS-1:0] en, input logic spi4, input logic [7:0] m0, input logic [7:0] m1);
    @(negedge clk);
    sig_en = en; spi4_mode = spi4;
    cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = m0;
    @(negedge clk);
    cfg_addr = 1'b1; cfg_wdata = m1;
    @(negedge clk);
    cfg_we = 1'b0;
    mask_now = {m1, m0};
  endtask

  task automatic t_reset();
    chk("R1", "pin_vld", int'(pin_vld), 0);
    chk("R1", "sig_vld", int'(sig_vld), 0);
    apply('0, 1'b0, 8'h00, 8'h00);
    check_all("R1");
  endtask

  task automatic t_full_walk();
    apply('1, 1'b1, 8'h00, 8'h00);
    check_all("R3");
    chk("R3", "SPI clock pin", int'(sig_pin[4*4 +: 4]), 0);
    chk("R3", "I2C data pin", int'(sig_pin[8*4 +: 4]), 6);
    chk("R5", "UART rx pin", int'(sig_pin[1*4 +: 4]), 5);
    chk("R6", "comparator sync pin", int'(sig_pin[3*4 +: 4]), 13);
    chk("R9", "timer 1 valid", int'(sig_vld[16]), 0);
    chk("R2", "pin 15 owner", int'(pin_owner[15*5 +: 5]), 15);
  endtask

  task automatic t_skip();
    apply('1, 1'b1, 8'h0C, 8'h00);
    check_all("R4");
    chk("R4", "MOSI pin after skip", int'(sig_pin[6*4 +: 4]), 6);
    chk("R9", "counter clock valid", int'(sig_vld[14]), 0);
    apply('1, 1'b1, 8'h00, 8'hC3);
    check_all("R4");
    chk("R4", "pin 8 free", int'(pin_vld[8]), 0);
  endtask

  task automatic t_fixed_over_skip();
    apply(17'h0000F, 1'b0, 8'h30, 8'h30);
    check_all("R5");
    chk("R5", "UART tx pin over mask", int'(sig_pin[0 +: 4]), 4);
    chk("R6", "comparator async pin over mask", int'(sig_pin[2*4 +: 4]), 12);
  endtask

  task automatic t_reservation();
    apply(17'h00400, 1'b0, 8'h0F, 8'h00);
    chk("R7", "sysclk takes free pin 4", int'(sig_pin[10*4 +: 4]), 4);
    apply(17'h00401, 1'b0, 8'h0F, 8'h00);
    chk("R7", "sysclk skips reserved 4", int'(sig_pin[10*4 +: 4]), 5);
    check_all("R7");
  endtask

  task automatic t_ssel();
    apply(17'h001F0, 1'b0, 8'h00, 8'h00);
    chk("R8", "slave select off in 3-wire", int'(sig_vld[7]), 0);
    chk("R8", "I2C data moves up", int'(sig_pin[8*4 +: 4]), 3);
    check_all("R8");
    apply(17'h001F0, 1'b1, 8'h00, 8'h00);
    chk("R8", "slave select on in 4-wire", int'(sig_pin[7*4 +: 4]), 3);
  endtask

  task automatic t_exhaust();
    apply('1, 1'b1, 8'hFF, 8'hFF);
    check_all("R9");
    chk("R9", "only fixed pins held", int'(pin_vld), 16'h3030);
  endtask

  task automatic t_latency();
    apply(17'h00010, 1'b1, 8'h00, 8'h00);
    chk("R10", "start pin", int'(sig_pin[4*4 +: 4]), 0);
    sig_en = 17'h00030;
    cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 8'h01;
    #1;
    chk("R10", "before edge MISO", int'(sig_vld[5]), 0);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R10", "SPI clock after edge", int'(sig_pin[4*4 +: 4]), 1);
    chk("R10", "MISO after edge", int'(sig_pin[5*4 +: 4]), 2);
    mask_now = 16'h0001;
  endtask

  initial begin
    rst = 1'b1; sig_en = '0; spi4_mode = 1'b0;
    cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0; mask_now = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full_walk();
    t_skip();
    t_fixed_over_skip();
    t_reservation();
    t_ssel();
    t_exhaust();
    t_latency();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule